// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects a small set of peripheral interrupt request lines. Each line is gated by its own bit of a software-writable mask. A fixed-priority encoder then picks one winner among the lines that survive the mask. A registered status flop records that some masked request is present. A software-controlled enable flop gates that status onto a single interrupt line to the processor.

When the processor reaches the end of an instruction, it raises a boundary strobe. If the interrupt line is high in that cycle, the block records that the interrupt has been taken, and it holds the index of the winning source. The processor then acknowledges. In response, the block delivers a vector address and clears the enable, so that no further interrupt is taken until software enables it again. The vector address is a fixed base constant with the winning index appended.

Software reaches the block through a single-cycle register write port. A two-bit select picks one of three actions: load the mask, load the enable, or clear the status flop.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A request line reaches the encoder only when its mask bit is 1; a masked-off request never raises `irq_out`. The mask loads from `cfg_wdata` on a write with `cfg_sel` = 0, and resets to all zeros.
- R2: When several unmasked requests are active together, the lowest-numbered line wins; line 0 has the highest priority.
- R3: The enable flop is loaded from `cfg_wdata[0]` on a write with `cfg_sel` = 1 and resets to 0. While it is 0, `irq_out` stays low whatever requests are present.
- R4: On every clock, the status flop loads the OR of all masked requests. `irq_out` is high exactly when both the enable flop and the status flop are 1, so `irq_out` falls within one clock of either flop becoming 0.
- R5: An interrupt is taken only on a clock where `boundary` and `irq_out` are both 1; a boundary strobe while `irq_out` is low has no effect.
- R6: An `ack` while an interrupt is taken makes `vec_valid` a one-clock pulse on the next clock, with `vec_out` = {`VEC_BASE`, winning index}, and clears the enable flop. An `ack` when no interrupt is taken produces no pulse.
- R7: The delivered index is the winner held at the clock the interrupt was taken; request changes after that point, including in the acknowledge cycle, do not alter `vec_out`.
- R8: A write with `cfg_sel` = 2 forces the status flop to 0 on that clock, so `irq_out` is low for the following cycle. A write with `cfg_sel` = 3 has no effect.
- R9: After reset, `irq_out`, `vec_valid` and `vec_out` are all 0, and `vec_out` changes only on a clock that raises `vec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 mask, 1 enable, 2 status clear, 3 none |
| cfg_wdata | input | NUM_SRC | Write data |
| irq_req | input | NUM_SRC | Peripheral request lines, bit 0 highest priority |
| boundary | input | 1 | End-of-instruction strobe from the processor |
| ack | input | 1 | Interrupt acknowledge from the processor |
| irq_out | output | 1 | Interrupt to the processor (enable AND status) |
| vec_out | output | VEC_W | Vector address {VEC_BASE, source index} |
| vec_valid | output | 1 | One-clock pulse marking a fresh vector |

## Verification
The bench uses a four-source configuration and sweeps every request pattern against every mask pattern. Where a masked request survives, it takes the interrupt and compares the delivered vector with the lowest set bit of the masked word, computed arithmetically. This separates a correct lowest-index priority from a reversed or partial one, and it separates a missing mask gate from a working one. Each delivery inverts the request lines during the acknowledge cycle, which shows whether the index is held from the take or read late. Directed sequences cover three cases: a disabled enable, where both the boundary strobe and `ack` must be ignored; a status-clear write, which must drop `irq_out` for one cycle before it recovers; and a write with the unused select, which must leave the mask unchanged.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   typedef enum logic [1:0] {
      SEL_MASK   = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_STCLR  = 2'd2,
      SEL_NONE   = 2'd3
   } cfg_sel_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned NUM_SRC = 8,
   localparam int unsigned IDX_W = irq_vec_pkg::idx_width(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] req_m,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);
   logic [NUM_SRC:0]   seen;
   logic [NUM_SRC-1:0] first;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
      assign first[i]  = req_m[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req_m[i];
   end

   assign any_o = seen[NUM_SRC];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (first[i]) idx_o = idx_o | IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [NUM_SRC-1:0] cfg_wdata,
   input  logic               ack_clear,
   input  logic               any_req,
   output logic [NUM_SRC-1:0] mask_q,
   output logic               en_q,
   output logic               st_q
);
   import irq_vec_pkg::*;

   logic wr_mask, wr_en, wr_clr;
   assign wr_mask = cfg_we && (cfg_sel == SEL_MASK);
   assign wr_en   = cfg_we && (cfg_sel == SEL_ENABLE);
   assign wr_clr  = cfg_we && (cfg_sel == SEL_STCLR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         en_q   <= 1'b0;
         st_q   <= 1'b0;
      end else begin
         if (wr_mask) mask_q <= cfg_wdata;
         if (ack_clear)  en_q <= 1'b0;
         else if (wr_en) en_q <= cfg_wdata[0];
         st_q <= wr_clr ? 1'b0 : any_req;
      end
   end
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit #(
   parameter int unsigned NUM_SRC  = 8,
   parameter int unsigned VEC_W    = 8,
   localparam int unsigned IDX_W   = irq_vec_pkg::idx_width(NUM_SRC),
   localparam int unsigned BASE_W  = VEC_W - IDX_W,
   parameter logic [BASE_W-1:0] VEC_BASE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [IDX_W-1:0] win_idx,
   input  logic             ack,
   output logic             taken_q,
   output logic             ack_hit,
   output logic [VEC_W-1:0] vec_out,
   output logic             vec_valid
);
   logic [IDX_W-1:0] held_idx;

   assign ack_hit = ack && taken_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taken_q   <= 1'b0;
         held_idx  <= '0;
         vec_out   <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= ack_hit;
         if (ack_hit) begin
            taken_q <= 1'b0;
            vec_out <= {VEC_BASE, held_idx};
         end else if (take) begin
            taken_q  <= 1'b1;
            held_idx <= win_idx;
         end
      end
   end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned VEC_W   = 8,
   localparam int unsigned IDX_W  = irq_vec_pkg::idx_width(NUM_SRC),
   localparam int unsigned BASE_W = VEC_W - IDX_W,
   parameter logic [BASE_W-1:0] VEC_BASE = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_sel,
   input  logic [NUM_SRC-1:0] cfg_wdata,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               boundary,
   input  logic               ack,
   output logic               irq_out,
   output logic [VEC_W-1:0]   vec_out,
   output logic               vec_valid
);
   if (NUM_SRC < 2 || NUM_SRC > 64) begin : g_bad_src
      $error("irq_vec_ctrl: NUM_SRC must lie in 2..64");
   end
   if (VEC_W <= IDX_W) begin : g_bad_vec
      $error("irq_vec_ctrl: VEC_W must exceed the index width");
   end

   logic [NUM_SRC-1:0] mask_q, req_m;
   logic               en_q, st_q, any_req, taken_q, ack_hit;
   logic [IDX_W-1:0]   enc_idx, win_q;

   assign req_m = irq_req & mask_q;

   irq_prio_enc #(.NUM_SRC(NUM_SRC)) enc_i (
      .req_m (req_m),
      .any_o (any_req),
      .idx_o (enc_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) win_q <= '0;
      else        win_q <= enc_idx;
   end

   irq_cfg_regs #(.NUM_SRC(NUM_SRC)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .ack_clear (ack_hit),
      .any_req   (any_req),
      .mask_q    (mask_q),
      .en_q      (en_q),
      .st_q      (st_q)
   );

   assign irq_out = en_q & st_q;

   irq_vec_unit #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) vec_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (boundary && irq_out),
      .win_idx   (win_q),
      .ack       (ack),
      .taken_q   (taken_q),
      .ack_hit   (ack_hit),
      .vec_out   (vec_out),
      .vec_valid (vec_valid)
   );
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned VEC_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic [1:0]         cfg_sel,
   input logic [NUM_SRC-1:0] irq_req,
   input logic [NUM_SRC-1:0] mask_q,
   input logic               boundary,
   input logic               ack,
   input logic               taken_q,
   input logic               irq_out,
   input logic [VEC_W-1:0]   vec_out,
   input logic               vec_valid
);
   // R1 / R4: no surviving request this cycle means no interrupt next cycle
   a_r1_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_req & mask_q) == '0) |=> !irq_out);

   // R5: a take only follows a boundary strobe with the interrupt line high
   a_r5_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(taken_q) |-> $past(boundary && irq_out));

   // R6: an accepted acknowledge drops the interrupt and yields a vector pulse
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && taken_q) |=> (!irq_out && vec_valid));

   // R6: a vector pulse always follows an acknowledge
   a_r6_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(ack));

   // R8: a status-clear write silences the interrupt for the next cycle
   a_r8_clear_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd2) |=> !irq_out);

   // R9: the vector is held between pulses
   a_r9_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> $stable(vec_out));
endmodule

bind irq_vec_ctrl irq_vec_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .irq_req   (irq_req),
   .mask_q    (mask_q),
   .boundary  (boundary),
   .ack       (ack),
   .taken_q   (taken_q),
   .irq_out   (irq_out),
   .vec_out   (vec_out),
   .vec_valid (vec_valid)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
   localparam int unsigned N    = 4;
   localparam int unsigned VW   = 8;
   localparam logic [5:0]  BASE = 6'h2D;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_sel = 2'd0;
   logic [N-1:0] cfg_wdata = '0;
   logic [N-1:0] irq_req = '0;
   logic         boundary = 1'b0;
   logic         ack = 1'b0;
   logic         irq_out;
   logic [VW-1:0] vec_out;
   logic         vec_valid;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_vec_ctrl #(.NUM_SRC(N), .VEC_W(VW), .VEC_BASE(BASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .irq_req(irq_req), .boundary(boundary),
      .ack(ack), .irq_out(irq_out), .vec_out(vec_out), .vec_valid(vec_valid)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   function automatic int lowest(input logic [N-1:0] v);
      for (int i = N - 1; i >= 0; i--) if (v[i]) lowest = i;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R9 reset state
      chk(irq_out == 1'b0, "R9 irq_out after reset", irq_out, 0);
      chk(vec_valid == 1'b0, "R9 vec_valid after reset", vec_valid, 0);
      chk(vec_out == '0, "R9 vec_out after reset", vec_out, 0);

      // R3 enable low: request present, boundary and ack ignored
      wr(2'd0, '1);
      irq_req = 4'b0100;
      tick(); tick();
      chk(irq_out == 1'b0, "R3 disabled irq_out", irq_out, 0);
      boundary = 1'b1; tick(); boundary = 1'b0;
      ack = 1'b1; tick(); ack = 1'b0;
      chk(vec_valid == 1'b0, "R5 boundary ignored when irq low", vec_valid, 0);
      wr(2'd1, 4'b0001);
      chk(irq_out == 1'b1, "R3 enable set", irq_out, 1);
      wr(2'd1, 4'b0000);
      chk(irq_out == 1'b0, "R3 enable cleared", irq_out, 0);

      // R8 status clear then recovery
      wr(2'd1, 4'b0001);
      tick();
      chk(irq_out == 1'b1, "R8 before clear", irq_out, 1);
      wr(2'd2, '0);
      chk(irq_out == 1'b0, "R8 after clear", irq_out, 0);
      tick();
      chk(irq_out == 1'b1, "R8 reload", irq_out, 1);

      // R8 unused select leaves mask alone
      wr(2'd3, '0);
      tick();
      chk(irq_out == 1'b1, "R8 sel3 no effect", irq_out, 1);

      // R6 ack with nothing taken
      ack = 1'b1; tick(); ack = 1'b0;
      chk(vec_valid == 1'b0, "R6 stray ack", vec_valid, 0);
      chk(irq_out == 1'b1, "R6 stray ack keeps enable", irq_out, 1);
      irq_req = '0;
      wr(2'd1, '0);

      // Sweep R1 R2 R4 R6 R7
      for (int m = 0; m < (1 << N); m++) begin
         for (int r = 0; r < (1 << N); r++) begin
            logic [N-1:0] mr;
            mr = N'(m) & N'(r);
            irq_req = N'(r);
            wr(2'd0, N'(m));
            wr(2'd1, 4'b0001);
            tick();
            chk(irq_out == (mr != 0), $sformatf("R1 R4 irq m=%0h r=%0h", m, r),
                irq_out, int'(mr != 0));
            if (mr != 0) begin
               boundary = 1'b1; tick(); boundary = 1'b0;
               ack = 1'b1; irq_req = ~N'(r); tick(); ack = 1'b0;
               chk(vec_valid == 1'b1, "R6 pulse", vec_valid, 1);
               chk(vec_out == {BASE, 2'(lowest(mr))},
                   $sformatf("R2 R7 vector m=%0h r=%0h", m, r),
                   vec_out, int'({BASE, 2'(lowest(mr))}));
               chk(irq_out == 1'b0, "R6 enable cleared", irq_out, 0);
               tick();
               chk(vec_valid == 1'b0, "R6 pulse width", vec_valid, 0);
            end else begin
               ack = 1'b1; tick(); ack = 1'b0;
               chk(vec_valid == 1'b0, "R6 ack without take", vec_valid, 0);
            end
            irq_req = '0;
            wr(2'd1, '0);
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule